// File: doc/BRIEF.md
# Shared SRAM Bus Ownership Sequencer

This block decides who drives a single local SRAM address/data bus that two masters share: a video scan-out engine, which reads pixels while the beam is on screen, and an external processor, which writes through a set of bus transceivers during the blanking gaps. The scan-out engine raises a display request while it needs the memory. The sequencer drives three registered outputs. The first is the SRAM output enable (active low). The second is the enable of the external transceivers (active low). The third is a grant that lets the processor write controller use the bus.

Every hand-over is break-before-make. The side that owns the bus is switched off first. A counted dead time follows, and only then is the other side switched on. A second counted wait gives the new driver time to settle before ownership is declared. The dead time is a parameter, so slower transceivers or SRAM parts can be covered by raising the count. The display request is assumed to be synchronous to the block clock.

Top module: `sram_bus_handover`

## Requirements
- R1: While reset is high, at every clock edge the SRAM output enable and the transceiver enable are both driven high (inactive), and the grant is driven low. After reset the sequencer sits in the video-owns state.
- R2: In the video-owns state, a clock edge that samples the display request low disables the SRAM outputs (output enable high) and starts a wait. Exactly WAIT_CYCLES+1 clock cycles later (6 with the default of 5), the transceiver enable is driven low.
- R3: Exactly WAIT_CYCLES+1 clock cycles after the transceivers are enabled, the grant is driven high and the processor-owns state begins.
- R4: In processor-owns, the first clock edge that samples the display request high drives the grant low and the transceiver enable high at that same edge.
- R5: Exactly WAIT_CYCLES+1 cycles after the transceivers are disabled, the SRAM output enable is driven low. WAIT_CYCLES+1 cycles after that, the video-owns state is re-entered, and the next edge that samples the request low starts a new hand-over.
- R6: During the four wait states, changes of the display request have no effect. A hand-over that has started always runs to completion.
- R7: The SRAM outputs and the transceivers are never enabled together. The grant is high only while the transceivers are enabled and the SRAM outputs are disabled.
- R8: While the grant is high and the request stays low, the grant stays high. While in video-owns with the request high, all three outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| display_req | input | 1 | High while the scan-out engine needs the SRAM bus |
| sram_oe_n | output | 1 | SRAM data output enable, active low |
| xcvr_oe_n | output | 1 | External bus transceiver enable, active low |
| proc_grant | output | 1 | Bus granted to the processor write controller |

## Verification
The assertions assume that the display request is a clean synchronous level that changes only between clock edges. They place no limit on how long the request holds a level or on when it toggles, because every pattern must keep the two drivers apart. The bench changes the request only at the falling clock edge. It mixes long steady stretches with random toggles, including toggles inside every wait state, so that both the ignored-request windows and the immediate release in processor-owns are exercised.

// File: rtl/handover_pkg.sv
package handover_pkg;

  typedef enum logic [2:0] {
    OWN_VIDEO   = 3'd0,
    WAIT_SRAM_Z = 3'd1,
    WAIT_XCVR_D = 3'd2,
    OWN_PROC    = 3'd3,
    WAIT_XCVR_Z = 3'd4,
    WAIT_SRAM_D = 3'd5
  } own_state_t;

  typedef struct packed {
    logic sram_off;
    logic xcvr_on;
    logic grant_on;
    logic release_bus;
    logic sram_on;
  } handover_ev_t;

  function automatic logic is_wait_state(own_state_t s);
    return (s == WAIT_SRAM_Z) || (s == WAIT_XCVR_D) ||
           (s == WAIT_XCVR_Z) || (s == WAIT_SRAM_D);
  endfunction

endpackage

// File: rtl/handover_dwell_ctr.sv
module handover_dwell_ctr #(
  parameter int unsigned WAIT_CYCLES = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic run,
  output logic done
);
  localparam int unsigned CW = (WAIT_CYCLES < 1) ? 1 : $clog2(WAIT_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(WAIT_CYCLES);

  logic [CW-1:0] cnt_q;

  assign done = (cnt_q >= LIMIT);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q <= '0;
    end else if (run && !done) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/handover_fsm.sv
module handover_fsm
  import handover_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         display_req,
  input  logic         wait_done,
  output logic         wait_clear,
  output logic         wait_run,
  output handover_ev_t ev
);
  own_state_t st_q, st_d;

  always_comb begin
    st_d       = st_q;
    wait_clear = 1'b0;
    ev         = '0;
    unique case (st_q)
      OWN_VIDEO: if (!display_req) begin
        st_d        = WAIT_SRAM_Z;
        wait_clear  = 1'b1;
        ev.sram_off = 1'b1;
      end
      WAIT_SRAM_Z: if (wait_done) begin
        st_d       = WAIT_XCVR_D;
        wait_clear = 1'b1;
        ev.xcvr_on = 1'b1;
      end
      WAIT_XCVR_D: if (wait_done) begin
        st_d        = OWN_PROC;
        wait_clear  = 1'b1;
        ev.grant_on = 1'b1;
      end
      OWN_PROC: if (display_req) begin
        st_d           = WAIT_XCVR_Z;
        wait_clear     = 1'b1;
        ev.release_bus = 1'b1;
      end
      WAIT_XCVR_Z: if (wait_done) begin
        st_d       = WAIT_SRAM_D;
        wait_clear = 1'b1;
        ev.sram_on = 1'b1;
      end
      WAIT_SRAM_D: if (wait_done) begin
        st_d       = OWN_VIDEO;
        wait_clear = 1'b1;
      end
      default: begin
        st_d       = OWN_VIDEO;
        wait_clear = 1'b1;
      end
    endcase
  end

  assign wait_run = is_wait_state(st_q);

  always_ff @(posedge clk) begin
    if (rst) st_q <= OWN_VIDEO;
    else     st_q <= st_d;
  end
endmodule

// File: rtl/handover_drive_regs.sv
module handover_drive_regs
  import handover_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  handover_ev_t ev,
  output logic         sram_oe_n,
  output logic         xcvr_oe_n,
  output logic         proc_grant
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sram_oe_n  <= 1'b1;
      xcvr_oe_n  <= 1'b1;
      proc_grant <= 1'b0;
    end else begin
      if (ev.sram_off)      sram_oe_n <= 1'b1;
      else if (ev.sram_on)  sram_oe_n <= 1'b0;

      if (ev.xcvr_on)          xcvr_oe_n <= 1'b0;
      else if (ev.release_bus) xcvr_oe_n <= 1'b1;

      if (ev.grant_on)         proc_grant <= 1'b1;
      else if (ev.release_bus) proc_grant <= 1'b0;
    end
  end
endmodule

// File: rtl/sram_bus_handover.sv
module sram_bus_handover #(
  parameter int unsigned WAIT_CYCLES = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic display_req,
  output logic sram_oe_n,
  output logic xcvr_oe_n,
  output logic proc_grant
);
  import handover_pkg::*;

  logic         wait_done;
  logic         wait_clear;
  logic         wait_run;
  handover_ev_t ev;

  handover_fsm fsm_i (
    .clk        (clk),
    .rst        (rst),
    .display_req(display_req),
    .wait_done  (wait_done),
    .wait_clear (wait_clear),
    .wait_run   (wait_run),
    .ev         (ev)
  );

  handover_dwell_ctr #(.WAIT_CYCLES(WAIT_CYCLES)) dwell_i (
    .clk  (clk),
    .rst  (rst),
    .clear(wait_clear),
    .run  (wait_run),
    .done (wait_done)
  );

  handover_drive_regs drive_i (
    .clk       (clk),
    .rst       (rst),
    .ev        (ev),
    .sram_oe_n (sram_oe_n),
    .xcvr_oe_n (xcvr_oe_n),
    .proc_grant(proc_grant)
  );
endmodule

// File: rtl/sram_bus_handover_chk.sv
module sram_bus_handover_chk #(
  parameter int unsigned WAIT_CYCLES = 5
) (
  input logic clk,
  input logic rst,
  input logic display_req,
  input logic sram_oe_n,
  input logic xcvr_oe_n,
  input logic proc_grant
);
  localparam int unsigned GW = 16;
  localparam logic [GW-1:0] DWELL = GW'(WAIT_CYCLES + 1);

  logic [GW-1:0] gap_q;
  logic [GW-1:0] xcvr_age_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q      <= '0;
      xcvr_age_q <= '0;
    end else begin
      if (sram_oe_n && xcvr_oe_n) gap_q <= (&gap_q) ? gap_q : gap_q + GW'(1);
      else                        gap_q <= '0;
      if (!xcvr_oe_n) xcvr_age_q <= (&xcvr_age_q) ? xcvr_age_q : xcvr_age_q + GW'(1);
      else            xcvr_age_q <= '0;
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (sram_oe_n && xcvr_oe_n && !proc_grant));

  assert_xcvr_dead_time_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(xcvr_oe_n) |-> (gap_q >= DWELL));

  assert_grant_settle_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(proc_grant) |-> (xcvr_age_q == DWELL));

  assert_fast_release_R4: assert property (@(posedge clk) disable iff (rst)
    (proc_grant && display_req) |=> (!proc_grant && xcvr_oe_n));

  assert_sram_dead_time_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(sram_oe_n) |-> (gap_q >= DWELL));

  assert_never_both_R7: assert property (@(posedge clk) disable iff (rst)
    !(!sram_oe_n && !xcvr_oe_n));

  assert_grant_path_R7: assert property (@(posedge clk) disable iff (rst)
    proc_grant |-> (!xcvr_oe_n && sram_oe_n));

  assert_grant_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (proc_grant && !display_req) |=> proc_grant);
endmodule

bind sram_bus_handover sram_bus_handover_chk #(.WAIT_CYCLES(WAIT_CYCLES)) chk_i (.*);

// File: tb/sram_bus_handover_tb_top.sv
module sram_bus_handover_tb_top;
  localparam int unsigned WAIT = 5;
  localparam int DW = WAIT + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic display_req = 1'b1;
  logic sram_oe_n, xcvr_oe_n, proc_grant;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  sram_bus_handover #(.WAIT_CYCLES(WAIT)) dut_i (
    .clk(clk), .rst(rst), .display_req(display_req),
    .sram_oe_n(sram_oe_n), .xcvr_oe_n(xcvr_oe_n), .proc_grant(proc_grant)
  );

  // Reference timeline built from the requirements: phase and remaining dwell.
  int m_phase = 0;
  int m_left  = 0;
  logic m_sram = 1'b1, m_xcvr = 1'b1, m_grant = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      m_phase = 0; m_sram = 1'b1; m_xcvr = 1'b1; m_grant = 1'b0;
    end else begin
      case (m_phase)
        0: if (!display_req) begin m_sram = 1'b1; m_phase = 1; m_left = DW - 1; end
        3: if (display_req) begin
             m_grant = 1'b0; m_xcvr = 1'b1; m_phase = 4; m_left = DW - 1;
           end
        default: begin
          if (m_left == 0) begin
            case (m_phase)
              1: begin m_xcvr = 1'b0; m_phase = 2; end
              2: begin m_grant = 1'b1; m_phase = 3; end
              4: begin m_sram = 1'b0; m_phase = 5; end
              default: m_phase = 0;
            endcase
            m_left = DW - 1;
          end else begin
            m_left = m_left - 1;
          end
        end
      endcase
    end
  end

  function automatic string phase_tag(int ph);
    case (ph)
      0, 1: return "R2";
      2:    return "R3";
      3:    return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    check({sram_oe_n, xcvr_oe_n, proc_grant} == {m_sram, m_xcvr, m_grant},
          phase_tag(m_phase), "outputs {sram_oe_n,xcvr_oe_n,grant}",
          int'({sram_oe_n, xcvr_oe_n, proc_grant}), int'({m_sram, m_xcvr, m_grant}));
    // R7: mutual exclusion and grant path
    check(!(!sram_oe_n && !xcvr_oe_n) && (!proc_grant || (!xcvr_oe_n && sram_oe_n)),
          "R7", "exclusive drive {sram_oe_n,xcvr_oe_n,grant}",
          int'({sram_oe_n, xcvr_oe_n, proc_grant}), 3'b100);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic steps_until_grant(output int n);
    n = 0;
    while (proc_grant !== 1'b1 && n < 200) begin step(); n++; end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stimulus
    int n;
    void'($urandom(32'd20240611));

    // R1: reset state
    @(negedge clk);
    for (int i = 0; i < 3; i++) step();
    check(sram_oe_n && xcvr_oe_n && !proc_grant, "R1", "reset outputs",
          int'({sram_oe_n, xcvr_oe_n, proc_grant}), 3'b110);
    rst = 1'b0;

    // R8: video-owns with request high holds outputs
    for (int i = 0; i < 8; i++) step();
    check(sram_oe_n && xcvr_oe_n && !proc_grant, "R8", "idle hold in video-owns",
          int'({sram_oe_n, xcvr_oe_n, proc_grant}), 3'b110);

    // R2 R3: first hand-over to the processor
    display_req = 1'b0;
    n = 0;
    while (xcvr_oe_n !== 1'b0 && n < 200) begin step(); n++; end
    check(n == DW + 1, "R2", "cycles to transceiver enable", n, DW + 1);
    steps_until_grant(n);
    check(n == DW, "R3", "cycles from transceiver enable to grant", n, DW);

    // R8: grant held while request low
    for (int i = 0; i < 5; i++) step();
    check(proc_grant == 1'b1, "R8", "grant hold", int'(proc_grant), 1);

    // R4: immediate release
    display_req = 1'b1;
    step();
    check(!proc_grant && xcvr_oe_n, "R4", "release at first high request",
          int'({xcvr_oe_n, proc_grant}), 2'b10);

    // R6 R5: request drops during release wait, ignored; SRAM re-enabled on time
    display_req = 1'b0;
    n = 0;
    while (sram_oe_n !== 1'b0 && n < 200) begin step(); n++; end
    check(n == DW, "R5", "cycles from release to SRAM enable", n, DW);
    check(proc_grant == 1'b0, "R6", "low request ignored in release wait",
          int'(proc_grant), 0);
    n = 0;
    while (sram_oe_n !== 1'b1 && n < 200) begin step(); n++; end
    check(n == DW + 1, "R5", "cycles to new hand-over after SRAM enable", n, DW + 1);

    // R6: request high throughout the waits does not abort the hand-over
    display_req = 1'b1;
    steps_until_grant(n);
    check(n == 2 * DW, "R6", "grant arrives despite high request", n, 2 * DW);
    step();
    check(!proc_grant && xcvr_oe_n, "R4", "release right after forced grant",
          int'({xcvr_oe_n, proc_grant}), 2'b10);

    // Random request patterns with mixed persistence
    for (int i = 0; i < 4000; i++) begin
      int unsigned odds;
      odds = (i < 2000) ? 32'd4 : 32'd23;
      if ($urandom % odds == 0) display_req = ~display_req;
      step();
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule